// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a recovered-clock oscillator runs close enough to its target frequency for a clock-recovery loop to leave frequency acquisition and start phase tracking. It counts oscillator cycles in the oscillator domain. Every measurement window of 2^WIN_LOG2 reference cycles, it takes the difference of two successive counter snapshots. That difference is compared with an expected count. The expected count depends on the selected data rate and on the selected reference frequency.

Two error limits give hysteresis. The tight limit is used to declare lock, and the loose limit is used to drop it, so a frequency error between the two limits leaves the lock state unchanged. The phase-loop enable output is the inverse of the loss-of-lock flag: it selects phase tracking while lock holds and hands control back to frequency acquisition when lock is lost. The output enable follows an external squelch request, and loss-of-lock may be wired straight into that request.

Top module: `freq_lock_det`

## Requirements
- R1: While reset is active and on the first cycles after it, `lol` is 1, `phase_loop_en` is 0 and `out_en` is 0.
- R2: At the end of a measurement window, if the previous window had already primed the measurement, an unlocked detector clears `lol` when |count − expected| ≤ expected >> 11 (about 488 ppm).
- R3: A locked detector keeps `lol` at 0 while |count − expected| ≤ expected >> 10 (about 977 ppm).
- R4: A locked detector sets `lol` to 1 at the end of a window in which |count − expected| > expected >> 10.
- R5: An unlocked detector keeps `lol` at 1 when the error lies above expected >> 11 but not above expected >> 10.
- R6: `phase_loop_en` is always the inverse of `lol`: 1 selects phase tracking and 0 selects frequency acquisition.
- R7: The expected count is (B << WIN_LOG2) >> 8 >> ref_sel. B is 2048, 8192, 32768 or 16461 for `rate_sel[1:0]` = 0, 1, 2 or 3 (the oscillator-to-19.44 MHz ratio times 256). `ref_sel` 0..3 selects 19.44, 38.88, 77.76 or 155.52 MHz. When `rate_sel[2]`=1 and `rate_sel[1:0]`≠3, the count is further multiplied by 15/14.
- R8: Any change of `ref_sel` or `rate_sel` sets `lol` to 1 on the next cycle and restarts the window. The first full window after the change only primes the measurement.
- R9: `out_en` is the inverse of `squelch`, delayed by one reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| osc_clk | input | 1 | Recovered-clock oscillator |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_sel | input | 2 | Reference frequency select |
| rate_sel | input | 3 | Data rate select |
| squelch | input | 1 | Request to force outputs off |
| lol | output | 1 | Loss-of-lock flag |
| phase_loop_en | output | 1 | 1 = phase tracking, 0 = frequency acquisition |
| out_en | output | 1 | Gated output enable |

## Verification
The oscillator is run at nominal frequency, about 800 ppm slow and about 1600 ppm slow. Each offset is applied from both the locked and the unlocked state. The 800 ppm case falls between the two limits, so it separates a working hysteresis from a single-threshold detector: it must hold an existing lock and must not acquire a new one. A second select pair that maps to the same expected count checks that the rate and reference table is decoded as a pair rather than from one select alone. The wrapper code must not lock at the native frequency. A select change made while locked must drop lock at once.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
package lockdet_pkg;

    // oscillator/19.44 MHz ratio scaled by 256, per native rate code
    function automatic logic [39:0] base_ratio(input logic [1:0] code);
        case (code)
            2'd0:    base_ratio = 40'd2048;
            2'd1:    base_ratio = 40'd8192;
            2'd2:    base_ratio = 40'd32768;
            default: base_ratio = 40'd16461;
        endcase
    endfunction

    function automatic logic [39:0] expected_count(input logic [2:0] rate,
                                                   input logic [1:0] refsel,
                                                   input int         win_log2);
        logic [39:0] cnt;
        cnt = (base_ratio(rate[1:0]) << win_log2) >> 8;
        cnt = cnt >> refsel;
        if (rate[2] && (rate[1:0] != 2'd3))
            cnt = (cnt * 40'd15) / 40'd14;
        return cnt;
    endfunction

endpackage

// File: rtl/lockdet_osc_gray.sv
`timescale 1ns/1ps
module lockdet_osc_gray #(
    parameter int CW = 23
) (
    input  logic          osc_clk,
    input  logic          rst_n,
    output logic [CW-1:0] gray_q
);
    logic [CW-1:0] bin_q, bin_d, gray_d;

    always_comb begin
        bin_d  = bin_q + 1'b1;
        gray_d = bin_q ^ (bin_q >> 1);
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= gray_d;
        end
    end
endmodule

// File: rtl/lockdet_gray_sync.sv
`timescale 1ns/1ps
module lockdet_gray_sync #(
    parameter int CW     = 23,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_in,
    output logic [CW-1:0] bin_out
);
    logic [CW-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= gray_in;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    always_comb begin
        bin_out[CW-1] = stage_q[STAGES-1][CW-1];
        for (int i = CW-2; i >= 0; i--)
            bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
    end
endmodule

// File: rtl/lockdet_err_eval.sv
`timescale 1ns/1ps
module lockdet_err_eval #(
    parameter int CW        = 23,
    parameter int ACQ_SHIFT = 11,
    parameter int REL_SHIFT = 10
) (
    input  logic [CW-1:0] meas,
    input  logic [CW-1:0] target,
    output logic          within_acq,
    output logic          beyond_rel
);
    logic [CW-1:0] err;

    always_comb begin
        err        = (meas > target) ? (meas - target) : (target - meas);
        within_acq = (err <= (target >> ACQ_SHIFT));
        beyond_rel = (err >  (target >> REL_SHIFT));
    end
endmodule

// File: rtl/freq_lock_det.sv
`timescale 1ns/1ps
module freq_lock_det #(
    parameter int WIN_LOG2 = 14
) (
    input  logic       ref_clk,
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic [1:0] ref_sel,
    input  logic [2:0] rate_sel,
    input  logic       squelch,
    output logic       lol,
    output logic       phase_loop_en,
    output logic       out_en
);
    import lockdet_pkg::*;

    localparam int CW = WIN_LOG2 + 9;

    typedef struct packed {
        logic [WIN_LOG2-1:0] win;
        logic [CW-1:0]       prev;
        logic                primed;
        logic                lol;
        logic [1:0]          ref_sel;
        logic [2:0]          rate;
        logic                oe;
    } ctl_t;

    ctl_t          st_d, st_q;
    logic [CW-1:0] osc_gray, snap, meas, target;
    logic [39:0]   target_full;
    logic          within_acq, beyond_rel, sel_chg, win_end;

    lockdet_osc_gray #(.CW(CW)) i_osc (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .gray_q  (osc_gray)
    );

    lockdet_gray_sync #(.CW(CW), .STAGES(2)) i_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .gray_in (osc_gray),
        .bin_out (snap)
    );

    lockdet_err_eval #(.CW(CW)) i_eval (
        .meas       (meas),
        .target     (target),
        .within_acq (within_acq),
        .beyond_rel (beyond_rel)
    );

    always_comb begin
        target_full = expected_count(st_q.rate, st_q.ref_sel, WIN_LOG2);
        target      = target_full[CW-1:0];
        meas        = snap - st_q.prev;
        sel_chg     = (ref_sel != st_q.ref_sel) || (rate_sel != st_q.rate);
        win_end     = &st_q.win;

        st_d    = st_q;
        st_d.oe = !squelch;
        if (sel_chg) begin
            st_d.ref_sel = ref_sel;
            st_d.rate    = rate_sel;
            st_d.win     = '0;
            st_d.primed  = 1'b0;
            st_d.lol     = 1'b1;
        end else begin
            st_d.win = st_q.win + 1'b1;
            if (win_end) begin
                st_d.prev   = snap;
                st_d.primed = 1'b1;
                if (st_q.primed) begin
                    if (st_q.lol && within_acq)
                        st_d.lol = 1'b0;
                    else if (!st_q.lol && beyond_rel)
                        st_d.lol = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.win     <= '0;
            st_q.prev    <= '0;
            st_q.primed  <= 1'b0;
            st_q.lol     <= 1'b1;
            st_q.ref_sel <= '0;
            st_q.rate    <= '0;
            st_q.oe      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lol           = st_q.lol;
    assign phase_loop_en = !st_q.lol;
    assign out_en        = st_q.oe;

    // no lock claimed without a primed measurement
    p_no_lock_unprimed_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !st_q.primed |-> st_q.lol);

    p_acquire_tight_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(st_q.lol) |-> $past(win_end && within_acq && !sel_chg));

    p_release_cause_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(st_q.lol) |-> $past(sel_chg || (win_end && beyond_rel)));

    p_hold_loose_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!st_q.lol && !sel_chg && !(win_end && beyond_rel)) |=> !st_q.lol);

    p_sel_restart_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        sel_chg |=> (st_q.lol && !st_q.primed && (st_q.win == '0)));
endmodule

// File: tb/test_freq_lock_det.sv
`timescale 1ns/1ps
module test_freq_lock_det;
    localparam int WL  = 12;
    localparam int WIN = 1 << WL;

    logic       ref_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] ref_sel = 2'd0;
    logic [2:0] rate_sel = 3'd0;
    logic       squelch = 1'b0;
    logic       lol, phase_loop_en, out_en;
    int         osc_half = 1250;
    int         total = 0;
    int         bad = 0;

    freq_lock_det #(.WIN_LOG2(WL)) i_freq_lock_det (
        .ref_clk       (ref_clk),
        .osc_clk       (osc_clk),
        .rst_n         (rst_n),
        .ref_sel       (ref_sel),
        .rate_sel      (rate_sel),
        .squelch       (squelch),
        .lol           (lol),
        .phase_loop_en (phase_loop_en),
        .out_en        (out_en)
    );

    always #10 ref_clk = ~ref_clk;
    always begin
        #(osc_half * 1ps);
        osc_clk = ~osc_clk;
    end

    task automatic check(input logic cond, input string what, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    task automatic check_lock(input logic exp_lol, input string what);
        check(lol == exp_lol, what, lol, exp_lol);
        check(phase_loop_en == !exp_lol, {what, " R6 phase_loop_en"}, phase_loop_en, !exp_lol);
    endtask

    task automatic t_reset;
        cycles(4);
        check_lock(1'b1, "R1 lol in reset");
        check(out_en == 1'b0, "R1 out_en in reset", out_en, 0);
        rst_n = 1'b1;
        cycles(3);
        check_lock(1'b1, "R1 lol after reset");
    endtask

    task automatic t_acquire;
        osc_half = 1250;
        cycles(3 * WIN);
        check_lock(1'b0, "R2 acquire at nominal");
    endtask

    task automatic t_hold_between;
        osc_half = 1251;
        cycles(3 * WIN);
        check_lock(1'b0, "R3 hold at 800ppm");
    endtask

    task automatic t_release;
        osc_half = 1252;
        cycles(3 * WIN);
        check_lock(1'b1, "R4 release at 1600ppm");
    endtask

    task automatic t_no_acquire_between;
        osc_half = 1251;
        cycles(3 * WIN);
        check_lock(1'b1, "R5 no acquire at 800ppm");
    endtask

    task automatic t_reacquire;
        osc_half = 1250;
        cycles(3 * WIN);
        check_lock(1'b0, "R2 reacquire at nominal");
    endtask

    task automatic t_select_table;
        rate_sel = 3'd1;
        ref_sel  = 2'd2;
        cycles(2);
        check_lock(1'b1, "R8 lol on select change");
        cycles(WIN);
        check_lock(1'b1, "R8 still unlocked in priming window");
        cycles(2 * WIN);
        check_lock(1'b0, "R7 lock with rate1 ref2");
    endtask

    task automatic t_wrapper;
        rate_sel = 3'd4;
        ref_sel  = 2'd0;
        cycles(3 * WIN);
        check_lock(1'b1, "R7 wrapper rate off nominal");
        rate_sel = 3'd0;
        cycles(3 * WIN);
        check_lock(1'b0, "R7 lock rate0 ref0");
    endtask

    task automatic t_squelch;
        squelch = 1'b1;
        cycles(1);
        check(out_en == 1'b0, "R9 out_en squelched", out_en, 0);
        check(lol == 1'b0, "R9 squelch leaves lock", lol, 0);
        squelch = 1'b0;
        cycles(1);
        check(out_en == 1'b1, "R9 out_en released", out_en, 1);
    endtask

    initial begin
        t_reset;
        t_acquire;
        t_hold_between;
        t_release;
        t_no_acquire_between;
        t_reacquire;
        t_select_table;
        t_wrapper;
        t_squelch;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(190000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule